// File: doc/BRIEF.md
# Time-multiplexed quad-port RAM

This block gives a design two independent write ports and two independent read ports, A and B, over one storage array that has a single write path and a single read path. The write path runs on a write clock and a companion clock at twice its rate. The read path runs on its own read clock and 2x companion, which need not be related to the write clocks. On each side the slow clock's level decides which port owns the array for the current half period. Each 2x rising edge performs one access for that owner. Every port therefore completes one access per slow-clock cycle.

The write side is `WR_DEPTH` words of `WR_WIDTH` bits. The read side is `RD_DEPTH` words, and its width is derived so that both views cover the same number of bits. A narrow read picks one slice of a stored word. A wide read joins adjacent stored words. Three build options are available: one registers the write inputs, one registers the read inputs, and one aligns port A's read data to the read clock's rising edge. Parameters are not checked, and the caller must pick legal values. A read of an address that is being written in the same period returns unpredictable data. Producing the 2x clocks and chaining several arrays are left to the surrounding design.

Top module: `qport_ram`

## Requirements
- R1: At a write 2x rising edge where `wr_clk` is high, port A's enabled write is committed. At an edge where it is low, port B's enabled write is committed. When both ports write the same address in one `wr_clk` cycle, B's data is the value that remains.
- R2: A write port whose enable is low leaves every stored word unchanged.
- R3: With `REG_WR_IN`=1, both ports' write enables, addresses and data are captured at the `wr_clk` rising edge. The captured values stay constant while `wr_clk` is high.
- R4: With the read input and output options off, addresses and enables presented during read-clock cycle n are delivered on `a_rd_data` and `b_rd_data` by the rising edge that starts cycle n+1. Port A is read at the 2x edge where `rd_clk` is high. Port B is read at the 2x edge where it is low, and `b_rd_data` never changes at a high-phase edge.
- R5: With `REG_RD_IN`=1, the read addresses and enables are captured at the `rd_clk` rising edge, which adds one read-clock cycle of latency.
- R6: With `REG_OUT`=1, `a_rd_data` changes only at the `rd_clk` rising edge. With both read options on, data for cycle n is on both outputs after the rising edge that starts cycle n+2.
- R7: A read port whose enable is low keeps its previous output value.
- R8: When `RD_WIDTH` < `WR_WIDTH`, read address r returns slice (r mod k) of stored word r/k, where k = `WR_WIDTH`/`RD_WIDTH`. Slice 0 is the least significant.
- R9: When `RD_WIDTH` > `WR_WIDTH`, read address r returns stored words r*k through r*k+k-1 concatenated, with the lowest address in the least significant bits.
- R10: While `rst_n` is low, both read outputs are zero.
- R11: `RD_WIDTH` equals `WR_WIDTH`*`WR_DEPTH`/`RD_DEPTH`. For example, 18 bits at 256 words on the write side gives 9 bits at 512 words or 36 bits at 128 words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset of control and output registers |
| wr_clk2x | input | 1 | Write-side access clock, twice the write data rate |
| wr_clk | input | 1 | Write data clock; its level selects port A (high) or B (low) |
| a_wr_en | input | 1 | Port A write enable |
| a_wr_addr | input | $clog2(WR_DEPTH) | Port A write address |
| a_wr_data | input | WR_WIDTH | Port A write data |
| b_wr_en | input | 1 | Port B write enable |
| b_wr_addr | input | $clog2(WR_DEPTH) | Port B write address |
| b_wr_data | input | WR_WIDTH | Port B write data |
| rd_clk2x | input | 1 | Read-side access clock, twice the read data rate |
| rd_clk | input | 1 | Read data clock; its level selects port A (high) or B (low) |
| a_rd_en | input | 1 | Port A read enable |
| a_rd_addr | input | $clog2(RD_DEPTH) | Port A read address |
| a_rd_data | output | RD_WIDTH | Port A read data |
| b_rd_en | input | 1 | Port B read enable |
| b_rd_addr | input | $clog2(RD_DEPTH) | Port B read address |
| b_rd_data | output | RD_WIDTH | Port B read data |

## Verification
The hardest case to reach is two writes landing on the same word within one write cycle. Only the phase order decides which one survives, and the result is visible only through a later read on another clock. The stimulus forces this case on every fourth write cycle of the second pass and disables single ports on other cycles. It then sweeps every read address on two instances, one narrow and fully registered and one wide and unregistered. Read enables drop on a fixed pattern while reads stream back to back, so held values and pipeline latency are checked on every cycle.

// File: rtl/qport_ram.sv
module qport_ram #(
  parameter int WR_DEPTH  = 256,
  parameter int WR_WIDTH  = 18,
  parameter int RD_DEPTH  = 512,
  parameter bit REG_WR_IN = 1'b0,
  parameter bit REG_RD_IN = 1'b0,
  parameter bit REG_OUT   = 1'b0,
  localparam int RD_WIDTH = WR_WIDTH * WR_DEPTH / RD_DEPTH,
  localparam int WA_W     = $clog2(WR_DEPTH),
  localparam int RA_W     = $clog2(RD_DEPTH)
) (
  input  logic                rst_n,
  input  logic                wr_clk2x,
  input  logic                wr_clk,
  input  logic                a_wr_en,
  input  logic [WA_W-1:0]     a_wr_addr,
  input  logic [WR_WIDTH-1:0] a_wr_data,
  input  logic                b_wr_en,
  input  logic [WA_W-1:0]     b_wr_addr,
  input  logic [WR_WIDTH-1:0] b_wr_data,
  input  logic                rd_clk2x,
  input  logic                rd_clk,
  input  logic                a_rd_en,
  input  logic [RA_W-1:0]     a_rd_addr,
  output logic [RD_WIDTH-1:0] a_rd_data,
  input  logic                b_rd_en,
  input  logic [RA_W-1:0]     b_rd_addr,
  output logic [RD_WIDTH-1:0] b_rd_data
);

  localparam int UNIT    = (WR_WIDTH < RD_WIDTH) ? WR_WIDTH : RD_WIDTH;
  localparam int W_UNITS = WR_WIDTH / UNIT;
  localparam int R_UNITS = RD_WIDTH / UNIT;
  localparam int N_UNITS = WR_DEPTH * W_UNITS;
  localparam int UA_W    = $clog2(N_UNITS);

  logic [UNIT-1:0] mem [N_UNITS];

  // Write side. A 2x edge that sees the slow clock low is its rising edge.
  logic                a_we_q, b_we_q;
  logic [WA_W-1:0]     a_wa_q, b_wa_q;
  logic [WR_WIDTH-1:0] a_wd_q, b_wd_q;

  generate
    if (REG_WR_IN) begin : g_wr_reg
      always_ff @(posedge wr_clk2x or negedge rst_n) begin
        if (!rst_n) begin
          a_we_q <= 1'b0;
          b_we_q <= 1'b0;
          a_wa_q <= '0;
          b_wa_q <= '0;
          a_wd_q <= '0;
          b_wd_q <= '0;
        end else if (!wr_clk) begin
          a_we_q <= a_wr_en;
          b_we_q <= b_wr_en;
          a_wa_q <= a_wr_addr;
          b_wa_q <= b_wr_addr;
          a_wd_q <= a_wr_data;
          b_wd_q <= b_wr_data;
        end
      end
    end else begin : g_wr_raw
      assign a_we_q = a_wr_en;
      assign b_we_q = b_wr_en;
      assign a_wa_q = a_wr_addr;
      assign b_wa_q = b_wr_addr;
      assign a_wd_q = a_wr_data;
      assign b_wd_q = b_wr_data;
    end
  endgenerate

  wire                w_en   = wr_clk ? a_we_q : b_we_q;
  wire [WA_W-1:0]     w_addr = wr_clk ? a_wa_q : b_wa_q;
  wire [WR_WIDTH-1:0] w_data = wr_clk ? a_wd_q : b_wd_q;

  always_ff @(posedge wr_clk2x) begin
    if (w_en) begin
      for (int k = 0; k < W_UNITS; k++)
        mem[UA_W'(int'(w_addr) * W_UNITS + k)] <= w_data[k*UNIT +: UNIT];
    end
  end

  // Read side
  logic            a_re_q, b_re_q;
  logic [RA_W-1:0] a_ra_q, b_ra_q;

  generate
    if (REG_RD_IN) begin : g_rd_reg
      always_ff @(posedge rd_clk2x or negedge rst_n) begin
        if (!rst_n) begin
          a_re_q <= 1'b0;
          b_re_q <= 1'b0;
          a_ra_q <= '0;
          b_ra_q <= '0;
        end else if (!rd_clk) begin
          a_re_q <= a_rd_en;
          b_re_q <= b_rd_en;
          a_ra_q <= a_rd_addr;
          b_ra_q <= b_rd_addr;
        end
      end
    end else begin : g_rd_raw
      assign a_re_q = a_rd_en;
      assign b_re_q = b_rd_en;
      assign a_ra_q = a_rd_addr;
      assign b_ra_q = b_rd_addr;
    end
  endgenerate

  wire            r_en   = rd_clk ? a_re_q : b_re_q;
  wire [RA_W-1:0] r_addr = rd_clk ? a_ra_q : b_ra_q;

  logic [RD_WIDTH-1:0] r_word;
  always_comb begin
    r_word = '0;
    for (int k = 0; k < R_UNITS; k++)
      r_word[k*UNIT +: UNIT] = mem[UA_W'(int'(r_addr) * R_UNITS + k)];
  end

  logic [RD_WIDTH-1:0] a_q, b_q;
  always_ff @(posedge rd_clk2x or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else if (r_en) begin
      if (rd_clk) a_q <= r_word;
      else        b_q <= r_word;
    end
  end

  generate
    if (REG_OUT) begin : g_out_reg
      logic [RD_WIDTH-1:0] a_out;
      always_ff @(posedge rd_clk2x or negedge rst_n) begin
        if (!rst_n)       a_out <= '0;
        else if (!rd_clk) a_out <= a_q;
      end
      assign a_rd_data = a_out;
    end else begin : g_out_raw
      assign a_rd_data = a_q;
    end
  endgenerate

  assign b_rd_data = b_q;

endmodule

module qport_ram_chk #(
  parameter int RD_W      = 9,
  parameter int RA_W      = 9,
  parameter int WA_W      = 8,
  parameter bit REG_WR_IN = 1'b0,
  parameter bit REG_RD_IN = 1'b0,
  parameter bit REG_OUT   = 1'b0
) (
  input logic            rst_n,
  input logic            wr_clk2x,
  input logic            wr_clk,
  input logic            rd_clk2x,
  input logic            rd_clk,
  input logic [RD_W-1:0] a_rd_data,
  input logic [RD_W-1:0] b_rd_data,
  input logic [RD_W-1:0] a_q,
  input logic            a_re_q,
  input logic [RA_W-1:0] a_ra_q,
  input logic [WA_W-1:0] a_wa_q
);

  assert_b_low_phase_only_R4: assert property (@(posedge rd_clk2x) disable iff (!rst_n)
    rd_clk |=> $stable(b_rd_data));

  assert_a_hold_when_idle_R7: assert property (@(posedge rd_clk2x) disable iff (!rst_n)
    (rd_clk && !a_re_q) |=> $stable(a_q));

  generate
    if (REG_OUT) begin : g_a_out
      assert_a_on_rise_only_R6: assert property (@(posedge rd_clk2x) disable iff (!rst_n)
        rd_clk |=> $stable(a_rd_data));
    end else begin : g_a_raw
      assert_a_on_fall_only_R4: assert property (@(posedge rd_clk2x) disable iff (!rst_n)
        !rd_clk |=> $stable(a_rd_data));
    end
    if (REG_RD_IN) begin : g_rin
      assert_rd_addr_held_R5: assert property (@(posedge rd_clk2x) disable iff (!rst_n)
        rd_clk |=> $stable(a_ra_q));
    end
    if (REG_WR_IN) begin : g_win
      assert_wr_addr_held_R3: assert property (@(posedge wr_clk2x) disable iff (!rst_n)
        wr_clk |=> $stable(a_wa_q));
    end
  endgenerate

endmodule

bind qport_ram qport_ram_chk #(
  .RD_W(RD_WIDTH), .RA_W(RA_W), .WA_W(WA_W),
  .REG_WR_IN(REG_WR_IN), .REG_RD_IN(REG_RD_IN), .REG_OUT(REG_OUT)
) u_chk (
  .rst_n(rst_n), .wr_clk2x(wr_clk2x), .wr_clk(wr_clk),
  .rd_clk2x(rd_clk2x), .rd_clk(rd_clk),
  .a_rd_data(a_rd_data), .b_rd_data(b_rd_data),
  .a_q(a_q), .a_re_q(a_re_q), .a_ra_q(a_ra_q), .a_wa_q(a_wa_q)
);

// File: tb/qport_ram_test.sv
`timescale 1ns/1ps
module qport_ram_test;
  logic rst_n = 1'b0;
  logic wclk2 = 1'b0, wclk = 1'b0, rclk2 = 1'b0, rclk = 1'b0;

  initial forever #2.5 wclk2 = ~wclk2;
  initial forever #3.3 rclk2 = ~rclk2;
  always @(posedge wclk2) wclk <= #1 ~wclk;
  always @(posedge rclk2) rclk <= #1 ~rclk;

  logic        a_we = 0, b_we = 0, a_re = 0, b_re = 0;
  logic [7:0]  a_wa = 0, b_wa = 0;
  logic [17:0] a_wd = 0, b_wd = 0;
  logic [8:0]  na_ra = 0, nb_ra = 0, na_rd, nb_rd;
  logic [6:0]  wa_ra = 0, wb_ra = 0;
  logic [35:0] wa_rd, wb_rd;

  qport_ram #(.RD_DEPTH(512), .REG_WR_IN(1'b1), .REG_RD_IN(1'b1), .REG_OUT(1'b1)) uut (
    .rst_n(rst_n), .wr_clk2x(wclk2), .wr_clk(wclk),
    .a_wr_en(a_we), .a_wr_addr(a_wa), .a_wr_data(a_wd),
    .b_wr_en(b_we), .b_wr_addr(b_wa), .b_wr_data(b_wd),
    .rd_clk2x(rclk2), .rd_clk(rclk),
    .a_rd_en(a_re), .a_rd_addr(na_ra), .a_rd_data(na_rd),
    .b_rd_en(b_re), .b_rd_addr(nb_ra), .b_rd_data(nb_rd));

  qport_ram #(.RD_DEPTH(128)) uut_wide (
    .rst_n(rst_n), .wr_clk2x(wclk2), .wr_clk(wclk),
    .a_wr_en(a_we), .a_wr_addr(a_wa), .a_wr_data(a_wd),
    .b_wr_en(b_we), .b_wr_addr(b_wa), .b_wr_data(b_wd),
    .rd_clk2x(rclk2), .rd_clk(rclk),
    .a_rd_en(a_re), .a_rd_addr(wa_ra), .a_rd_data(wa_rd),
    .b_rd_en(b_re), .b_rd_addr(wb_ra), .b_rd_data(wb_rd));

  int errors = 0, checks = 0;
  bit done = 0;
  logic [17:0] model [256];
  logic [8:0]  cna = 0, cnb = 0;
  logic [35:0] cwa = 0, cwb = 0;

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [17:0] wdat(int addr, int pass, int isb);
    return 18'(addr * 613 + pass * 40999 + isb * 7777 + 11);
  endfunction

  function automatic logic [8:0] exp_n(int r);
    logic [17:0] w;
    w = model[r >> 1];
    return r[0] ? w[17:9] : w[8:0];
  endfunction

  function automatic logic [35:0] exp_w(int r);
    return {model[2*r+1], model[2*r]};
  endfunction

  task automatic wr_pass(int pass);
    for (int c = 0; c < 128; c++) begin
      bit coll;
      @(posedge wclk); #1;
      coll = (pass == 1) && (c % 4 == 0);
      a_wa = 8'(2*c);
      b_wa = coll ? 8'(2*c) : 8'(2*c + 1);
      a_wd = wdat(2*c, pass, 0);
      b_wd = wdat(int'(b_wa), pass, 1);
      a_we = (pass == 0) || coll || (c % 3 != 0);
      b_we = (pass == 0) || coll || (c % 5 != 1);
      if (a_we) model[a_wa] = a_wd;
      if (b_we) model[b_wa] = b_wd;
    end
    @(posedge wclk); #1;
    a_we = 0; b_we = 0;
    repeat (4) @(posedge wclk);
    repeat (3) @(posedge rclk);
  endtask

  task automatic rd_pass(string tn, string tw);
    logic [8:0]  hna [516];
    logic [8:0]  hnb [516];
    logic [35:0] hwa [516];
    logic [35:0] hwb [516];
    hna[0] = cna; hna[1] = cna; hnb[0] = cnb; hnb[1] = cnb;
    hwa[0] = cwa; hwa[1] = cwa; hwb[0] = cwb; hwb[1] = cwb;
    for (int k = 0; k < 514; k++) begin
      @(posedge rclk); #1;
      chk(tn, {27'd0, na_rd}, {27'd0, hna[k]});
      chk(tn, {27'd0, nb_rd}, {27'd0, hnb[k]});
      chk(tw, wa_rd, hwa[k+1]);
      chk(tw, wb_rd, hwb[k+1]);
      if (k < 512) begin
        a_re = (k % 7 != 3);
        b_re = (k % 5 != 2);
        na_ra = 9'(k);
        nb_ra = 9'(511 - k);
        wa_ra = 7'(k % 128);
        wb_ra = 7'((3*k + 1) % 128);
      end else begin
        a_re = 0; b_re = 0;
      end
      if (a_re) begin cna = exp_n(int'(na_ra)); cwa = exp_w(int'(wa_ra)); end
      if (b_re) begin cnb = exp_n(int'(nb_ra)); cwb = exp_w(int'(wb_ra)); end
      hna[k+2] = cna; hnb[k+2] = cnb; hwa[k+2] = cwa; hwb[k+2] = cwb;
    end
  endtask

  initial begin
    #50;
    chk("R10", {27'd0, na_rd}, 36'd0);
    chk("R10", {27'd0, nb_rd}, 36'd0);
    chk("R10", wa_rd, 36'd0);
    chk("R10", wb_rd, 36'd0);
    chk("R11", 36'($bits(na_rd)), 36'd9);
    chk("R11", 36'($bits(wa_rd)), 36'd36);
    #3 rst_n = 1'b1;
    wr_pass(0);
    rd_pass("R3/R5/R6/R7/R8", "R4/R7/R9");
    wr_pass(1);
    rd_pass("R1/R2/R3/R5/R6/R7/R8", "R1/R2/R4/R7/R9");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule